// File: doc/BRIEF.md
# HDLC Receive Buffer Interrupt Controller

This block sits behind a bit-level HDLC deframer. The deframer hands it received bytes one at a time, along with strobes that mark the end of a message, an abort, and the result of the frame check. The bytes go into an eight-entry buffer that is split into two halves of four entries each. While the deframer fills one half, the processor empties the other.

The block raises an interrupt for three reasons:
- a half of the buffer has filled,
- a message has closed, or
- an abort has arrived.

The processor reads a status byte to find the cause. Reading it also clears the pending interrupt. The status byte packs the following fields:
- a three-bit buffer location (bits [5:3]),
- an idle bit (bit 2),
- a frame-check-failure bit (bit 1),
- an abort bit (bit 0).

A second register reports whether an interrupt is pending and does not clear it. Two enable inputs gate the interrupt pin. After every message close or abort, the block stays silent until four bytes of the next message have arrived. Every message therefore starts at buffer location 0.

Top module: `hdlc_rxbuf_irq`

## Requirements
- R1: Each byte strobed in with `rx_valid` is written at the current location, which then advances by one and wraps from 7 to 0. A read of offset 0x40+i returns location i on `rd_data` one cycle after `rd_en`.
- R2: A byte written at location 3 or 7 while interrupts are armed sets the pending interrupt. The status becomes location = that location, idle 0, check-fail 0, abort 0. This gives 0x18 for the lower half and 0x38 for the upper half.
- R3: A message close (`rx_eom`, alone or together with the last byte) while armed sets the pending interrupt. The status becomes location = last location written, idle 1, check-fail = `rx_fcs_bad`. An 8-byte payload followed by two check bytes gives 0x0C, or 0x0E when the check fails.
- R4: An abort while armed sets the pending interrupt with status 0x05 (location 000, idle 1, abort 1). A byte strobed in the same cycle as the abort is not stored.
- R5: After reset, and after every message close or abort, the write location returns to 0 and no interrupt is raised until the fourth byte of the new message. That fourth byte can itself raise one.
- R6: When a message close lands on a byte at location 3 or 7, the close takes priority and the status shows idle 1. An abort takes priority over a message close in the same cycle.
- R7: A read of offset 0x14 returns the status and clears the pending interrupt. If a new interrupt is raised in the same cycle as the read, the interrupt stays pending and the read returns the previous status.
- R8: `irq` is high only when an interrupt is pending and both `mode_en` and `rx_irq_en` are 1.
- R9: A read of offset 0x15 returns the pending flag in bit 0 and does not clear it. Unmapped offsets read as 0.
- R10: After reset, `irq` is 0, nothing is pending, and the status reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe from the deframer |
| rx_data | input | 8 | Received byte |
| rx_eom | input | 1 | Message close strobe |
| rx_abort | input | 1 | Abort strobe |
| rx_fcs_bad | input | 1 | Frame check failed, qualified by `rx_eom` |
| mode_en | input | 1 | Mode-level interrupt enable |
| rx_irq_en | input | 1 | Receiver interrupt enable |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 7 | Register offset |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| irq | output | 1 | Gated interrupt output |

## Verification
The assertions assume that the strobes are synchronous, single-cycle and free of X. They also assume that `rx_fcs_bad` is meaningful only together with `rx_eom`. Given those assumptions, the assertions tie each newly raised interrupt to the strobe that was present one cycle earlier.

The assertions do not assume that the processor keeps up with the buffer. Overrun is not modelled, so the directed stimulus always reads a half before that half refills. The stimulus also drives a status read in the same cycle as an interrupt-raising byte only in the single test built for that collision.

// File: rtl/hdlc_rxbuf_irq.sv
module hdlc_rxbuf_irq #(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter logic [AW-1:0] STAT_OFS = 7'h14,
  parameter logic [AW-1:0] SRC_OFS  = 7'h15,
  parameter logic [AW-1:0] BUF_OFS  = 7'h40,
  parameter int ARM_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eom,
  input  logic          rx_abort,
  input  logic          rx_fcs_bad,
  input  logic          mode_en,
  input  logic          rx_irq_en,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int DEPTH = 8;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(ARM_BYTES);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, idx;
  logic [CW-1:0] cnt;
  logic          sup, pend, idle, bad, abt;

  wire wr        = rx_valid & ~rx_abort;
  wire fourth    = wr & (cnt == CW'(ARM_BYTES - 1));
  wire armed     = ~sup | fourth;
  wire half_done = wr & (&wptr[PW-2:0]);
  wire [PW-1:0] last = wr ? wptr : wptr - 1'b1;
  wire stat_rd   = rd_en & (rd_addr == STAT_OFS);

  wire set_abt = rx_abort & ~sup;
  wire set_eom = ~rx_abort & rx_eom & armed;
  wire set_hf  = ~rx_abort & ~rx_eom & half_done & armed;
  wire raise   = set_abt | set_eom | set_hf;

  wire [DW-1:0] stat = DW'({idx, idle, bad, abt});
  wire in_buf = (rd_addr >= BUF_OFS) && (rd_addr < BUF_OFS + AW'(DEPTH));
  wire [AW-1:0] boff = rd_addr - BUF_OFS;

  assign irq = pend & mode_en & rx_irq_en;

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      cnt  <= '0;
      sup  <= 1'b1;
    end else if (rx_abort || rx_eom) begin
      wptr <= '0;
      cnt  <= '0;
      sup  <= 1'b1;
    end else if (wr) begin
      wptr <= wptr + 1'b1;
      if (sup) begin
        cnt <= cnt + 1'b1;
        if (fourth) sup <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      idx  <= '0;
      idle <= 1'b1;
      bad  <= 1'b0;
      abt  <= 1'b0;
    end else begin
      pend <= raise | (pend & ~stat_rd);
      if (set_abt) begin
        idx <= '0; idle <= 1'b1; bad <= 1'b0; abt <= 1'b1;
      end else if (set_eom) begin
        idx <= last; idle <= 1'b1; bad <= rx_fcs_bad; abt <= 1'b0;
      end else if (set_hf) begin
        idx <= wptr; idle <= 1'b0; bad <= 1'b0; abt <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      if (rd_addr == STAT_OFS)     rd_data <= stat;
      else if (rd_addr == SRC_OFS) rd_data <= DW'(pend);
      else if (in_buf)             rd_data <= mem[boff[PW-1:0]];
      else                         rd_data <= '0;
    end
  end
endmodule

// File: rtl/hdlc_rxbuf_irq_chk.sv
module hdlc_rxbuf_irq_chk #(
  parameter int AW = 7,
  parameter logic [AW-1:0] STAT_OFS = 7'h14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_eom,
  input logic          rx_abort,
  input logic          rx_fcs_bad,
  input logic          mode_en,
  input logic          rx_irq_en,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          irq,
  input logic          pend,
  input logic [2:0]    idx,
  input logic          idle,
  input logic          bad,
  input logic          abt
);
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode_en && rx_irq_en));

  a_r2_half_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend) && !$past(rx_eom) && !$past(rx_abort)) |-> (idx[1:0] == 2'b11 && !idle && !abt && !bad));

  a_r3_eom_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend) && $past(rx_eom) && !$past(rx_abort)) |-> (idle && !abt && bad == $past(rx_fcs_bad)));

  a_r4_abort_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend) && $past(rx_abort)) |-> (abt && idle && idx == 3'd0));

  a_r5_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_eom) || $past(rx_abort)) |=> !$rose(pend));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == STAT_OFS && !rx_valid && !rx_eom && !rx_abort) |=> !pend);

  a_r2_no_cause_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !rx_valid && !rx_eom && !rx_abort) |=> !pend);
endmodule

bind hdlc_rxbuf_irq hdlc_rxbuf_irq_chk #(.AW(AW), .STAT_OFS(STAT_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eom(rx_eom),
  .rx_abort(rx_abort), .rx_fcs_bad(rx_fcs_bad), .mode_en(mode_en),
  .rx_irq_en(rx_irq_en), .rd_en(rd_en), .rd_addr(rd_addr), .irq(irq),
  .pend(pend), .idx(idx), .idle(idle), .bad(bad), .abt(abt)
);

// File: tb/hdlc_rxbuf_irq_bench.sv
module hdlc_rxbuf_irq_bench;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_eom = 0, rx_abort = 0, rx_fcs_bad = 0;
  logic [7:0] rx_data = 0;
  logic mode_en = 1, rx_irq_en = 1, rd_en = 0;
  logic [6:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic irq;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  hdlc_rxbuf_irq u_hdlc_rxbuf_irq (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eom(rx_eom), .rx_abort(rx_abort), .rx_fcs_bad(rx_fcs_bad),
    .mode_en(mode_en), .rx_irq_en(rx_irq_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic eom = 0, logic ab = 0, logic fb = 0);
    rx_valid = 1; rx_data = d; rx_eom = eom; rx_abort = ab; rx_fcs_bad = fb;
    @(negedge clk);
    rx_valid = 0; rx_eom = 0; rx_abort = 0; rx_fcs_bad = 0;
  endtask

  task automatic strobe(logic eom, logic ab, logic fb = 0);
    rx_eom = eom; rx_abort = ab; rx_fcs_bad = fb;
    @(negedge clk);
    rx_eom = 0; rx_abort = 0; rx_fcs_bad = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic t_reset;
    chk("R10", "irq after reset", 8'(irq), 8'h00);
    rd(7'h15, v); chk("R10", "pending after reset", v, 8'h00);
    rd(7'h14, v); chk("R10", "status after reset", v, 8'h04);
    rd(7'h00, v); chk("R9", "unmapped offset", v, 8'h00);
  endtask

  task automatic t_message;
    for (int i = 0; i < 3; i++) send(8'hA0 + 8'(i));
    chk("R5", "no irq before 4th byte", 8'(irq), 8'h00);
    send(8'hA3);
    chk("R2", "irq lower half", 8'(irq), 8'h01);
    rd(7'h14, v); chk("R2", "status lower half", v, 8'h18);
    chk("R7", "irq cleared by read", 8'(irq), 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd(7'h40 + 7'(i), v); chk("R1", "lower half byte", v, 8'hA0 + 8'(i));
    end
    for (int i = 4; i < 8; i++) send(8'hA0 + 8'(i));
    rd(7'h14, v); chk("R2", "status upper half", v, 8'h38);
    rd(7'h47, v); chk("R1", "upper half byte", v, 8'hA7);
    send(8'hF1);
    chk("R1", "no irq at location 0", 8'(irq), 8'h00);
    send(8'hF2, 1, 0, 1);
    rd(7'h14, v); chk("R3", "status end with bad check", v, 8'h0E);
    rd(7'h41, v); chk("R1", "wrapped check byte", v, 8'hF2);
  endtask

  task automatic t_priority;
    for (int i = 0; i < 3; i++) send(8'hB0 + 8'(i));
    send(8'hB3, 1);
    rd(7'h14, v); chk("R6", "close beats half full", v, 8'h1C);
    rd(7'h43, v); chk("R1", "last byte stored", v, 8'hB3);
  endtask

  task automatic t_short;
    for (int i = 0; i < 3; i++) send(8'hC0 + 8'(i));
    strobe(1, 0);
    chk("R5", "short frame irq", 8'(irq), 8'h00);
    rd(7'h15, v); chk("R5", "short frame pending", v, 8'h00);
  endtask

  task automatic t_abort;
    for (int i = 0; i < 4; i++) send(8'hD0 + 8'(i));
    rd(7'h14, v); chk("R2", "status before abort", v, 8'h18);
    send(8'hD4);
    send(8'hEE, 0, 1);
    chk("R4", "irq on abort", 8'(irq), 8'h01);
    rd(7'h14, v); chk("R4", "status on abort", v, 8'h05);
    rd(7'h45, v); chk("R4", "byte with abort dropped", v, 8'hA5);
    for (int i = 0; i < 4; i++) send(8'h10 + 8'(i));
    rd(7'h14, v); chk("R5", "restart after abort", v, 8'h18);
    rd(7'h40, v); chk("R5", "new frame at location 0", v, 8'h10);
  endtask

  task automatic t_suppress;
    strobe(1, 1);
    rd(7'h14, v); chk("R6", "abort beats close", v, 8'h05);
    send(8'h20); send(8'h21);
    strobe(0, 1);
    chk("R5", "abort while quiet", 8'(irq), 8'h00);
    rd(7'h15, v); chk("R5", "quiet pending", v, 8'h00);
  endtask

  task automatic t_gate;
    mode_en = 0;
    for (int i = 0; i < 4; i++) send(8'h30 + 8'(i));
    chk("R8", "mode disabled", 8'(irq), 8'h00);
    rd(7'h15, v); chk("R9", "source pending", v, 8'h01);
    rd(7'h15, v); chk("R9", "source read keeps pending", v, 8'h01);
    mode_en = 1; #1;
    chk("R8", "both enabled", 8'(irq), 8'h01);
    rx_irq_en = 0; #1;
    chk("R8", "rx enable off", 8'(irq), 8'h00);
    rx_irq_en = 1; #1;
    @(negedge clk);
  endtask

  task automatic t_collide;
    send(8'h34); send(8'h35); send(8'h36);
    rx_valid = 1; rx_data = 8'h37; rd_en = 1; rd_addr = 7'h14;
    @(negedge clk);
    rx_valid = 0; rd_en = 0;
    chk("R7", "read returns old status", rd_data, 8'h18);
    chk("R7", "new irq survives read", 8'(irq), 8'h01);
    rd(7'h14, v); chk("R7", "second read", v, 8'h38);
    send(8'h40); send(8'h41);
    strobe(1, 0);
    rd(7'h14, v); chk("R3", "close alone good check", v, 8'h0C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_message();
    t_priority();
    t_short();
    t_abort();
    t_suppress();
    t_gate();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule